// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block lets synchronous logic use an external asynchronous static RAM that is 16 bits wide, has active-low chip, write and output strobes, and has a separate active-low enable for each byte lane. A host hands over one request at a time through a valid/ready handshake. Each request carries a direction, an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The sequencer then runs the memory strobes through a fixed series of phases. Each phase lasts a whole number of system-clock cycles, derived from nanosecond parameters so that the memory's minimum pulse, setup and hold times are met. When the request is finished, a single-cycle done pulse is raised. For reads, the returned word is presented with that pulse.

Back-pressure is simple. `req_ready` is high only while the sequencer is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host must hold its request fields steady. The done pulse has no ready of its own and cannot be stalled. The data pins are split into an output word, an output-enable and an input word, so the pad ring builds the shared bidirectional bus. The sequencer turns the output-enable on only inside the write-enable pulse.

Top module: `sram_byte_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. It is 0 from the cycle after an accepting edge through the cycle that carries `rsp_done`, so a request held valid during the done cycle is not taken then.
- R2: A write drops `mem_we_n` (with `mem_ce_n` low and `mem_oe_n` high) for exactly WR_CYC consecutive cycles. WR_CYC is the largest of ceil(T_WP_NS/CLK_NS), ceil(T_BW_NS/CLK_NS) and ceil(T_SD_NS/CLK_NS), which is 3 at the defaults (20 ns clock; 45, 60, 30 ns).
- R3: While `mem_ce_n` is low, `mem_lb_n` is low exactly when mask bit 0 is 1 (bits 7:0), and `mem_ub_n` is low exactly when mask bit 1 is 1 (bits 15:8).
- R4: `mem_dq_oe` is 1 only while `mem_we_n` is low, and during that time `mem_dq_out` equals the request's write data.
- R5: `mem_addr` shows the request address for one cycle before `mem_we_n` falls, stays steady throughout the pulse, and stays for one cycle after it rises.
- R6: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for RD_CYC = ceil(T_RC_NS/CLK_NS) cycles (3 at the defaults). The word on `mem_dq_in` is captured on the last edge of that phase.
- R7: In the returned read word, a lane whose mask bit is 0 reads as zero.
- R8: `rsp_done` is high for exactly one cycle per request. It comes WR_CYC+3 cycles after the accepting edge for a write and RD_CYC+1 cycles after it for a read. `rsp_rdata` is valid in that cycle.
- R9: While idle and in the done cycle, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all high and `mem_dq_oe` is 0 (standby).
- R10: After `mem_oe_n` has been low, at least one cycle with `mem_oe_n` high passes before `mem_dq_oe` rises.
- R11: A request with mask 00 still completes with its done pulse. Neither lane enable is driven low, and a write stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, valid with rsp_done |
| mem_addr | output | 18 | Memory address pins |
| mem_dq_out | output | 16 | Data to drive onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data sampled from the memory bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |

## Verification
Two things can happen in the same cycle: the done pulse of one request and the presentation of the next. The bench provokes this by raising `req_valid` for a new request in the very cycle `rsp_done` is seen. It then judges that `req_ready` is low there, and that the new request's latency counts from the following idle cycle. The other collision is a write issued directly after a read. Here the output-enable release and the first bus drive must not share a cycle, and a bench monitor checks that on every rise of `mem_dq_oe`.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_WHOLD   = 3'd3,
    ST_RACCESS = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_t;

  function automatic int cycles_for(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_lane_unit.sv
module sram_lane_unit #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    capture,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES-1:0]        lane_n,
  output logic [LANES*LANE_W-1:0] rdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i] = ~(active & mask[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rdata[i*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rdata[i*LANE_W +: LANE_W] <= mask[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/sram_byte_seq.sv
module sram_byte_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int LANE_W  = 8,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 20,
  parameter int T_WP_NS = 45,
  parameter int T_BW_NS = 60,
  parameter int T_SD_NS = 30,
  parameter int T_RC_NS = 45
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_mask,
  output logic                    rsp_done,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_in,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic                    mem_lb_n,
  output logic                    mem_ub_n
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int WR_CYC = max3(cycles_for(T_WP_NS, CLK_NS),
                               cycles_for(T_BW_NS, CLK_NS),
                               cycles_for(T_SD_NS, CLK_NS));
  localparam int RD_CYC = cycles_for(T_RC_NS, CLK_NS);
  localparam int MAX_CYC = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int CNT_W  = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);

  seq_state_t        state, state_nxt;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic              accept;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic              t_last;
  logic              mem_active;
  logic              rd_capture;
  logic [LANES-1:0]  lane_n;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_comb begin
    state_nxt = state;
    t_load    = 1'b0;
    t_val     = RD_LOAD;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (req_write) state_nxt = ST_WSETUP;
        else begin
          state_nxt = ST_RACCESS;
          t_load    = 1'b1;
          t_val     = RD_LOAD;
        end
      end
      ST_WSETUP: begin
        state_nxt = ST_WPULSE;
        t_load    = 1'b1;
        t_val     = WR_LOAD;
      end
      ST_WPULSE:  if (t_last) state_nxt = ST_WHOLD;
      ST_WHOLD:   state_nxt = ST_DONE;
      ST_RACCESS: if (t_last) state_nxt = ST_DONE;
      ST_DONE:    state_nxt = ST_IDLE;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  assign mem_active = (state == ST_WSETUP) || (state == ST_WPULSE) ||
                      (state == ST_WHOLD)  || (state == ST_RACCESS);
  assign rd_capture = (state == ST_RACCESS) && t_last;

  sram_lane_unit #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (mem_active),
    .capture (rd_capture),
    .mask    (mask_q),
    .dq_in   (mem_dq_in),
    .lane_n  (lane_n),
    .rdata   (rsp_rdata)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (state == ST_WPULSE) && wr_q;
  assign mem_ce_n   = ~mem_active;
  assign mem_we_n   = ~(state == ST_WPULSE);
  assign mem_oe_n   = ~(state == ST_RACCESS);
  assign mem_lb_n   = lane_n[0];
  assign mem_ub_n   = lane_n[LANES-1];
  assign rsp_done   = (state == ST_DONE);
endmodule

// File: rtl/sram_byte_seq_chk.sv
module sram_byte_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int WR_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n
);
  logic [7:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else                we_run <= '0;
  end

  p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);
  p_we_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));
  p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && we_run != 0) |-> (we_run >= 8'(WR_CYC)));
  p_lanes_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_lb_n && mem_ub_n));
  p_bus_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);
  p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || $rose(mem_we_n)) |-> $stable(mem_addr));
  p_read_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || rsp_done) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  p_turnaround_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));
endmodule

bind sram_byte_seq sram_byte_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYC(WR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
  .mem_ub_n(mem_ub_n)
);

// File: tb/sim_sram_byte_seq.sv
module sim_sram_byte_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, rsp_done;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;
  logic        mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;

  int checks = 0, errors = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  sram_byte_seq u0 (.*);

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int exp_wr();
    int m;
    m = cdiv(45, 20);
    if (cdiv(60, 20) > m) m = cdiv(60, 20);
    if (cdiv(30, 20) > m) m = cdiv(30, 20);
    return m;
  endfunction
  function automatic int exp_rd();
    return cdiv(45, 20);
  endfunction

  // memory model and independent reference
  logic [15:0] model [logic [17:0]];
  logic [15:0] refm  [logic [17:0]];

  function automatic logic [15:0] mget(input logic [17:0] a);
    return model.exists(a) ? model[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] rget(input logic [17:0] a);
    return refm.exists(a) ? refm[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] apply_mask(input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
  endfunction

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mget(mem_addr) : 16'hA5C3;

  always @(posedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = mget(mem_addr);
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      model[mem_addr] = w;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // protocol monitor
  logic [1:0]  cur_mask;
  logic [15:0] cur_wdata;
  logic [17:0] cur_addr;
  int  we_low = 0;
  bit  prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
  logic [17:0] prev_addr;

  always @(negedge clk) begin
    if (running) begin
      if (!mem_ce_n)
        check(mem_lb_n == !cur_mask[0] && mem_ub_n == !cur_mask[1], "R3", "lane enables",
              {mem_ub_n, mem_lb_n}, {~cur_mask[1], ~cur_mask[0]});
      if (mem_dq_oe)
        check(!mem_we_n && mem_dq_out == cur_wdata, "R4", "bus drive",
              {mem_we_n, mem_dq_out}, {1'b0, cur_wdata});
      if (!mem_we_n) we_low++;
      if (mem_we_n && !prev_we_n) begin
        check(we_low == exp_wr(), "R2", "we pulse width", we_low, exp_wr());
        check(mem_addr == cur_addr && prev_addr == cur_addr, "R5", "address hold",
              mem_addr, cur_addr);
        we_low = 0;
      end
      if (!mem_we_n && prev_we_n)
        check(prev_addr == cur_addr, "R5", "address setup", prev_addr, cur_addr);
      if (mem_dq_oe && !prev_dq_oe)
        check(prev_oe_n, "R10", "turnaround before drive", prev_oe_n, 1);
      if (req_ready || rsp_done)
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
              "R9", "standby", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
              6'b111110);
      if (!mem_oe_n)
        check(mem_we_n && !mem_ce_n, "R6", "read strobes", {mem_we_n, mem_ce_n}, 2'b10);
    end
    prev_we_n  = mem_we_n;
    prev_oe_n  = mem_oe_n;
    prev_dq_oe = mem_dq_oe;
    prev_addr  = mem_addr;
  end

  // one request; called at a negedge, returns at the done negedge
  task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m);
    int n;
    int oe_cycles;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    if (rsp_done) begin
      check(!req_ready, "R1", "ready low in done cycle", req_ready, 0);
      @(negedge clk);
    end
    while (!req_ready) @(negedge clk);
    cur_mask = m; cur_wdata = d; cur_addr = a;
    @(posedge clk);
    n = 0; oe_cycles = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        check(!req_ready, "R1", "ready low when busy", req_ready, 0);
        req_valid = 1'b0;
      end
      if (!mem_oe_n) oe_cycles++;
    end while (!rsp_done && n < 40);
    if (wr) begin
      check(n == exp_wr() + 3, "R8", "write done latency", n, exp_wr() + 3);
      refm[a] = {m[1] ? d[15:8] : rget(a)[15:8], m[0] ? d[7:0] : rget(a)[7:0]};
    end else begin
      check(n == exp_rd() + 1, "R8", "read done latency", n, exp_rd() + 1);
      check(oe_cycles == exp_rd(), "R6", "read access length", oe_cycles, exp_rd());
      check(rsp_rdata == apply_mask(rget(a), m), "R7", "read data",
            rsp_rdata, apply_mask(rget(a), m));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_done && mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n &&
          mem_ub_n && !mem_dq_oe, "R9", "reset state",
          {req_ready, rsp_done, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
          8'b10111110);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1", "ready after reset", req_ready, 1);
    running = 1'b1;

    // directed corners
    do_req(1'b1, 18'h3FFFF, 16'hBEEF, 2'b11);
    do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11);   // back-to-back after done
    do_req(1'b1, 18'h00000, 16'h1234, 2'b01);
    do_req(1'b1, 18'h00000, 16'hABCD, 2'b10);
    do_req(1'b0, 18'h00000, 16'h0000, 2'b11);
    do_req(1'b0, 18'h00000, 16'h0000, 2'b10);   // R7 low lane zero
    do_req(1'b1, 18'h00000, 16'h5555, 2'b00);   // R11 no lane
    do_req(1'b0, 18'h00000, 16'h0000, 2'b11);   // R11 data unchanged
    do_req(1'b0, 18'h00005, 16'h0000, 2'b00);   // R11 read completes, zero
    do_req(1'b1, 18'h00005, 16'h0F0F, 2'b11);   // R10 write right after read

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [17:0] a;
      a = ($urandom % 4 == 0) ? 18'h3FFF0 + 18'($urandom % 16) : 18'($urandom % 16);
      do_req(1'($urandom), a, 16'($urandom), 2'($urandom));
      if ($urandom % 3 == 0) repeat ($urandom % 3 + 1) @(negedge clk);
    end

    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule